// File: doc/BRIEF.md
# Reed-Solomon Systematic Parity Encoder

This block turns a block of 8-bit data symbols into a systematic Reed-Solomon codeword with six check symbols, for a mother code of 255 symbols (249 data, 6 parity). Data symbols come in on a valid/ready stream with a last marker. They go out on a second valid/ready stream unchanged and in order. At the same time, a six-stage register of field symbols divides the message by the generator polynomial. Once the last data symbol has been taken, the six remainder symbols are sent out, and the last one of them carries the output last marker.

Shorter blocks are encoded directly, with no zero padding. A block of any length from 1 to 249 symbols produces the codeword of the shortened code. The encoder stops taking input while it sends parity. On both streams a transfer happens only in a cycle where valid and ready are both high. During the data phase the input ready follows the output ready, so back-pressure passes straight through. During the parity phase the output holds its symbol until it is taken.

Top module: `rs_encoder`

## Requirements
- R1: After reset, out_valid and size_err are low, and in_ready equals out_ready.
- R2: In the data phase, every accepted data symbol appears on out_data unchanged and in order, with out_last low. In that phase in_ready follows out_ready, so with out_ready low no input is taken.
- R3: After a symbol marked in_last is accepted, exactly six parity symbols follow. out_last is high only on the sixth, and in_ready stays low until that symbol has been taken.
- R4: The parity is the remainder of D(x)·x^6 divided by g(x) = (x+α^0)(x+α^1)…(x+α^5) over GF(2^8), built on the field polynomial 0x11D with α = 0x02. The first symbol of the codeword is the highest power. Parity is sent highest-order coefficient first. As a result, every codeword evaluates to zero at α^0…α^5. A single data symbol 0x01 gives first parity 0x3F and last parity 0x26, and an all-zero block gives all-zero parity.
- R5: Any block length from 1 to 249 is encoded as the shortened code. Each codeword starts from a cleared division register, whatever came before it.
- R6: Data symbols beyond the 249th are still accepted (in_ready high) but are discarded and not forwarded. size_err is high for one cycle, in the cycle after each discarded symbol. The parity covers the first 249 symbols, and an in_last on a discarded symbol still ends the block.
- R7: While a parity symbol is offered and out_ready is low, out_data and out_valid hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | Encoder can take an input symbol |
| in_data | input | 8 | Input data symbol |
| in_last | input | 1 | Marks the final data symbol of a block |
| out_valid | output | 1 | Output symbol valid |
| out_ready | input | 1 | Downstream can take an output symbol |
| out_data | output | 8 | Data or parity symbol |
| out_last | output | 1 | Marks the final parity symbol |
| size_err | output | 1 | One-cycle pulse per discarded oversize symbol |

## Verification
Two functions can fall in the same cycle. The first is closing a block with in_last, which also starts the parity phase. The second is discarding an oversize symbol. The bench sends a 252-symbol block whose in_last sits on a discarded symbol. It then checks three things: the scoreboard sees exactly 249 forwarded symbols followed by six correct parity symbols; three size_err pulses are counted; and the next block encodes cleanly. Every codeword is also judged by evaluating it at the six roots, which does not depend on the bench's own division model.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  localparam int SYM_W   = 8;
  localparam int MAX_PAR = 32;
  // field polynomial 0x11D, low byte used after the carry-out
  localparam logic [SYM_W-1:0] FIELD_LOW = 8'h1D;
  localparam logic [SYM_W-1:0] ALPHA     = 8'h02;

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [MAX_PAR:0][SYM_W-1:0] gen_poly_t;
  typedef enum logic {PH_DATA, PH_PARITY} phase_e;

  // shift-and-add multiply in GF(2^8)
  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc;
    sym_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      if (sh[SYM_W-1]) sh = (sh << 1) ^ FIELD_LOW;
      else             sh = sh << 1;
    end
    return acc;
  endfunction

  // coefficients of prod (x + alpha^i), i = 0..npar-1; index = power of x
  function automatic gen_poly_t gen_poly(int npar);
    gen_poly_t g;
    sym_t root;
    g    = '0;
    g[0] = 8'h01;
    root = 8'h01;
    for (int i = 0; i < MAX_PAR; i++) begin
      if (i < npar) begin
        for (int j = MAX_PAR; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
        g[0] = gf_mul(g[0], root);
        root = gf_mul(root, ALPHA);
      end
    end
    return g;
  endfunction
endpackage

// File: rtl/rs_gf_cmul.sv
module rs_gf_cmul
  import rs_enc_pkg::*;
#(
  parameter sym_t K = 8'h01
) (
  input  logic [SYM_W-1:0] x,
  output logic [SYM_W-1:0] y
);
  // constant operand folds the multiplier into a fixed XOR network
  assign y = gf_mul(x, K);
endmodule

// File: rtl/rs_parity_lfsr.sv
module rs_parity_lfsr
  import rs_enc_pkg::*;
#(
  parameter int NPAR = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] din,
  input  logic             absorb,
  input  logic             drain,
  output logic [SYM_W-1:0] par_out,
  output logic             empty
);
  localparam gen_poly_t GEN = gen_poly(NPAR);

  sym_t stage_q [NPAR];
  sym_t prod    [NPAR];
  sym_t fb;

  assign fb      = din ^ stage_q[NPAR-1];
  assign par_out = stage_q[NPAR-1];

  for (genvar j = 0; j < NPAR; j++) begin : g_stage
    rs_gf_cmul #(.K(GEN[j])) u_mul (.x(fb), .y(prod[j]));
    if (j == 0) begin : g_low
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stage_q[j] <= '0;
        else if (absorb) stage_q[j] <= prod[j];
        else if (drain)  stage_q[j] <= '0;
      end
    end else begin : g_mid
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stage_q[j] <= '0;
        else if (absorb) stage_q[j] <= stage_q[j-1] ^ prod[j];
        else if (drain)  stage_q[j] <= stage_q[j-1];
      end
    end
  end

  always_comb begin
    empty = 1'b1;
    for (int j = 0; j < NPAR; j++) if (stage_q[j] != '0) empty = 1'b0;
  end

  // the controller must never ask for division and draining together
  assert_no_absorb_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(absorb && drain));
endmodule

// File: rtl/rs_frame_ctl.sv
module rs_frame_ctl
  import rs_enc_pkg::*;
#(
  parameter int KMAX = 249,
  parameter int NPAR = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_last,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic out_last,
  output logic absorb,
  output logic drain,
  output logic sel_parity,
  output logic size_err
);
  localparam int CNT_W  = $clog2(KMAX + 1);
  localparam int PCNT_W = (NPAR > 1) ? $clog2(NPAR) : 1;

  phase_e             phase_q;
  logic [CNT_W-1:0]   dcnt_q;
  logic [PCNT_W-1:0]  pcnt_q;
  logic               full;
  logic               drop;
  logic               take;
  logic               err_q;

  assign full       = (dcnt_q == CNT_W'(KMAX));
  assign sel_parity = (phase_q == PH_PARITY);
  assign size_err   = err_q;

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_last  = 1'b0;
    absorb    = 1'b0;
    drain     = 1'b0;
    drop      = 1'b0;
    if (phase_q == PH_DATA) begin
      in_ready  = full | out_ready;
      out_valid = in_valid & ~full;
      absorb    = in_valid & out_ready & ~full;
      drop      = in_valid & full;
    end else begin
      out_valid = 1'b1;
      out_last  = (pcnt_q == PCNT_W'(NPAR - 1));
      drain     = out_ready;
    end
  end

  assign take = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_DATA;
      dcnt_q  <= '0;
      pcnt_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= drop;
      if (phase_q == PH_DATA) begin
        if (absorb) dcnt_q <= dcnt_q + CNT_W'(1);
        if (take && in_last) begin
          phase_q <= PH_PARITY;
          pcnt_q  <= '0;
        end
      end else if (drain) begin
        if (out_last) begin
          phase_q <= PH_DATA;
          dcnt_q  <= '0;
        end else begin
          pcnt_q <= pcnt_q + PCNT_W'(1);
        end
      end
    end
  end

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt_q <= CNT_W'(KMAX));
  assert_err_after_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !out_valid && phase_q == PH_DATA) |=> size_err);
endmodule

// File: rtl/rs_encoder.sv
module rs_encoder
  import rs_enc_pkg::*;
#(
  parameter int NSYM = 255,
  parameter int NPAR = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       size_err
);
  localparam int KMAX = NSYM - NPAR;

  logic absorb;
  logic drain;
  logic sel_parity;
  logic lfsr_empty;
  sym_t par_sym;

  rs_frame_ctl #(.KMAX(KMAX), .NPAR(NPAR)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_last(in_last), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .out_last(out_last),
    .absorb(absorb), .drain(drain), .sel_parity(sel_parity),
    .size_err(size_err)
  );

  rs_parity_lfsr #(.NPAR(NPAR)) u_lfsr (
    .clk(clk), .rst_n(rst_n),
    .din(in_data), .absorb(absorb), .drain(drain),
    .par_out(par_sym), .empty(lfsr_empty)
  );

  assign out_data = sel_parity ? par_sym : in_data;

  assert_parity_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_parity && !out_ready) |=> ($stable(out_data) && out_valid));
  assert_clean_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> lfsr_empty);
endmodule

// File: tb/rs_encoder_test.sv
module rs_encoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_last = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_last;
  logic       size_err;

  always #4 clk = ~clk;

  rs_encoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .size_err(size_err)
  );

  int checks = 0;
  int fails = 0;
  int err_seen = 0;
  int exp_err = 0;
  int ready_pct = 100;
  int gap_pct = 0;
  int unsigned lcg_d = 32'h1234_5678;
  int unsigned lcg_r = 32'h0bad_cafe;
  logic [9:0] expq [$];            // {is_parity, last, data}
  logic [7:0] cw [$];
  logic [7:0] obs_par [0:5];
  int         par_idx = 0;
  logic [7:0] msg [0:299];
  logic [7:0] gref [0:6];

  task automatic check(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  // field multiply written independently: reduce a, walk bits of b from the top
  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] acc;
    acc = '0;
    for (int i = 7; i >= 0; i--) begin
      acc = {acc[7:0], 1'b0};
      if (acc[8]) acc = acc ^ 9'h11D;
      if (b[i]) acc = acc ^ {1'b0, a};
    end
    return acc[7:0];
  endfunction

  function automatic logic [7:0] apow(input int e);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 0; i < e; i++) r = fmul(r, 8'h02);
    return r;
  endfunction

  task automatic build_gen();
    for (int j = 0; j < 7; j++) gref[j] = 8'h00;
    gref[0] = 8'h01;
    for (int i = 0; i < 6; i++) begin
      for (int j = 6; j >= 1; j--) gref[j] = gref[j-1] ^ fmul(gref[j], apow(i));
      gref[0] = fmul(gref[0], apow(i));
    end
  endtask

  function automatic logic [7:0] next_d();
    lcg_d = lcg_d * 32'd1103515245 + 32'd12345;
    return lcg_d[23:16];
  endfunction

  // ready generator, changes just after the rising edge
  initial begin
    forever begin
      @(posedge clk); #1;
      lcg_r = lcg_r * 32'd1664525 + 32'd1013904223;
      out_ready = (int'(lcg_r[30:24]) % 100) < ready_pct;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && size_err) err_seen++;
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, "R6 unexpected output", int'(out_data), 0);
      end else begin
        logic [9:0] e;
        e = expq.pop_front();
        if (e[9]) begin
          check(out_data == e[7:0], "R4 parity symbol", int'(out_data), int'(e[7:0]));
          check(in_ready == 1'b0, "R3 input stalled in parity", int'(in_ready), 0);
          if (par_idx < 6) obs_par[par_idx] = out_data;
          par_idx++;
        end else begin
          check(out_data == e[7:0], "R2 data pass-through", int'(out_data), int'(e[7:0]));
        end
        check(out_last == e[8], "R3 out_last placement", int'(out_last), int'(e[8]));
      end
      cw.push_back(out_data);
      if (out_last) begin
        for (int i = 0; i < 6; i++) begin
          logic [7:0] s;
          logic [7:0] ai;
          ai = apow(i);
          s = 8'h00;
          foreach (cw[k]) s = fmul(s, ai) ^ cw[k];
          check(s == 8'h00, "R4 codeword root", int'(s), 0);
        end
        cw.delete();
      end
    end
  end

  task automatic run_word(input int len, input int pat);
    logic [7:0] rr [0:5];
    logic [7:0] fb;
    int k;
    for (int i = 0; i < len; i++) begin
      case (pat)
        0: msg[i] = 8'h00;
        1: msg[i] = next_d();
        2: msg[i] = 8'(i + 1);
        default: msg[i] = 8'hFF;
      endcase
    end
    k = (len > 249) ? 249 : len;
    for (int j = 0; j < 6; j++) rr[j] = 8'h00;
    for (int i = 0; i < k; i++) begin
      fb = msg[i] ^ rr[5];
      for (int j = 5; j >= 1; j--) rr[j] = rr[j-1] ^ fmul(gref[j], fb);
      rr[0] = fmul(gref[0], fb);
      expq.push_back({1'b0, 1'b0, msg[i]});
    end
    for (int j = 5; j >= 0; j--) expq.push_back({1'b1, (j == 0), rr[j]});
    exp_err += len - k;
    par_idx = 0;
    for (int i = 0; i < len; i++) begin
      if ((int'(next_d()) % 100) < gap_pct) begin
        @(posedge clk); #1;
      end
      in_valid = 1'b1;
      in_data  = msg[i];
      in_last  = (i == len - 1);
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_last  = 1'b0;
    end
  endtask

  task automatic drain_all();
    while (expq.size() > 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, actual=0 expected=1");
    finish_run();
  end

  initial begin
    build_gen();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(size_err == 1'b0, "R1 size_err after reset", int'(size_err), 0);
    check(in_ready == out_ready, "R1 in_ready follows out_ready", int'(in_ready), int'(out_ready));

    // R2 back-pressure while idle in data phase
    ready_pct = 0;
    @(posedge clk); @(negedge clk);
    check(in_ready == 1'b0, "R2 in_ready low with out_ready low", int'(in_ready), 0);
    ready_pct = 100;
    @(posedge clk); @(negedge clk);
    check(in_ready == 1'b1, "R2 in_ready high with out_ready high", int'(in_ready), 1);
    @(posedge clk); #1;

    // R4 single symbol 0x01: parity equals generator coefficients
    msg[0] = 8'h01;
    run_word(1, 2);
    drain_all();
    check(obs_par[0] == 8'h3F, "R4 first parity of 0x01", int'(obs_par[0]), 8'h3F);
    check(obs_par[5] == 8'h26, "R4 last parity of 0x01", int'(obs_par[5]), 8'h26);

    // R4 all-zero block
    run_word(10, 0);
    drain_all();
    for (int j = 0; j < 6; j++)
      check(obs_par[j] == 8'h00, "R4 zero block parity", int'(obs_par[j]), 0);

    // R2 R7 random data under back-pressure and input gaps
    ready_pct = 60; gap_pct = 30;
    run_word(37, 1);
    drain_all();

    // R5 full-length block, then short blocks back to back
    ready_pct = 70; gap_pct = 10;
    run_word(249, 2);
    run_word(1, 1);
    run_word(2, 1);
    run_word(3, 3);
    drain_all();
    check(err_seen == 0, "R5 no size error up to 249", err_seen, 0);

    ready_pct = 40; gap_pct = 0;
    run_word(100, 3);
    drain_all();

    // R6 oversize block with in_last on a discarded symbol
    ready_pct = 80;
    run_word(252, 1);
    drain_all();
    check(err_seen == exp_err, "R6 size_err pulse count", err_seen, exp_err);
    check(exp_err == 3, "R6 discarded symbols", exp_err, 3);

    // R5 clean restart after oversize
    ready_pct = 50; gap_pct = 20;
    run_word(20, 1);
    drain_all();
    check(expq.size() == 0, "R3 scoreboard drained", expq.size(), 0);
    check(err_seen == 3, "R6 no stray size_err", err_seen, 3);

    finish_run();
  end
endmodule